// File: doc/BRIEF.md
# Free-Running Capture Timer Channel

This block is one timer channel. After a start trigger it counts clock cycles upward from zero. Each time a selected transition appears on an asynchronous external input, it copies the running count into a capture register. A capture does not reset the count, so the difference between two captured values is the time between the two events. Software reads the capture register and the status outputs whenever it needs them.

Starting and stopping happen through single-cycle trigger inputs, which act like self-clearing command bits. A separate `running` status output shows whether the channel is enabled. Every capture produces a one-clock interrupt pulse. When the start-interrupt enable is set, a start also produces a one-clock interrupt pulse.

Edge detection runs on a synchronised copy of the input. The edge-select field may be changed at any time and takes effect at once. The counter wraps around at its top value and records each wrap in a sticky overflow flag.

Top module: `tcap_top`

## Requirements
- R1: While `rst_n` is low, and after it is released, `running`, `count`, `cap_data`, `irq` and `ovf` are all 0.
- R2: When `trig_start` is high at a clock edge and `trig_stop` is low, `running` is 1 and `count` is 0 after that edge. After that, `count` goes up by 1 at every edge while the channel runs. A start while the channel is already running restarts the count from 0.
- R3: A start with `start_irq_en`=1 gives `irq`=1 for exactly the cycle after the start edge. A start with `start_irq_en`=0 gives no start pulse.
- R4: A change of `cap_in` that is sampled at edge k reaches the edge detector through two synchroniser flops. If the change is a selected edge and the channel is running, then at edge k+2 `cap_data` takes the `count` value held just before that edge, and `irq` is 1 for one cycle.
- R5: A capture never clears or pauses `count`; it goes on incrementing, and every later selected edge captures again.
- R6: `edge_sel` encoding: 2'b00 = falling edges, 2'b01 = rising edges, 2'b10 = both edges, 2'b11 = no edge. A change of `edge_sel` applies at the very next clock edge, even while the channel runs.
- R7: When `trig_stop` is high at an edge, `running` is 0 after that edge and `count` keeps the value it held before that edge. Stop wins over a start in the same cycle.
- R8: Selected edges give no capture and no `irq` while the channel is stopped, and none in a cycle where `trig_stop` is high.
- R9: `count` is CNT_W bits wide (default 32) and wraps from all-ones to 0. The wrap sets `ovf`, which stays 1 until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_start | input | 1 | One-cycle start command |
| trig_stop | input | 1 | One-cycle stop command; wins over start |
| start_irq_en | input | 1 | When 1, a start also raises `irq` |
| edge_sel | input | 2 | Capture edge: 00 fall, 01 rise, 10 both, 11 none |
| cap_in | input | 1 | Asynchronous event input |
| running | output | 1 | Channel enabled status |
| count | output | CNT_W | Live counter value |
| cap_data | output | CNT_W | Last captured count |
| irq | output | 1 | One-cycle interrupt pulse |
| ovf | output | 1 | Sticky counter-wrap flag |

## Verification
A bad enable state appears at once on `running`. On the next edge it also appears on `count`, which then either freezes or keeps moving when it should not. A wrong synchroniser or edge-detector state appears as a capture that comes one cycle early or late, or comes at the wrong polarity. Both `cap_data` and `irq` show this within three edges of the `cap_in` change. A lost overflow bit is seen on `ovf` one edge after the wrap, and it stays wrong until the next start. The bench compares every output on every cycle, so any such error is reported in the cycle it first reaches a port.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_NONE = 2'b11
  } edge_mode_e;
endpackage

// File: rtl/tcap_edge_det.sv
module tcap_edge_det
  import tcap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap_in,
  input  logic [1:0] edge_sel,
  output logic       hit
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   rise, fall;

  // synchroniser chain, one flop per stage
  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= cap_in;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= sync_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[LAST];

  assign rise = sync_q[LAST] & ~prev_q;
  assign fall = ~sync_q[LAST] & prev_q;

  always_comb begin
    unique case (edge_mode_e'(edge_sel))
      EDGE_FALL: hit = fall;
      EDGE_RISE: hit = rise;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/tcap_ctrl.sv
module tcap_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_start,
  input  logic trig_stop,
  input  logic start_irq_en,
  output logic running,
  output logic restart,
  output logic count_en,
  output logic start_irq
);
  logic run_q;

  // stop has priority over start
  assign restart   = trig_start & ~trig_stop;
  assign count_en  = run_q & ~trig_stop;
  assign start_irq = restart & start_irq_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          run_q <= 1'b0;
    else if (trig_stop)  run_q <= 1'b0;
    else if (trig_start) run_q <= 1'b1;

  assign running = run_q;
endmodule

// File: rtl/tcap_counter.sv
module tcap_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             count_en,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  assign wrap = count_en & ~restart & (cnt_q == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        cnt_q <= '0;
    else if (restart)  cnt_q <= '0;
    else if (count_en) cnt_q <= cnt_q + 1'b1;

  assign count = cnt_q;
endmodule

// File: rtl/tcap_top.sv
module tcap_top #(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_start,
  input  logic             trig_stop,
  input  logic             start_irq_en,
  input  logic [1:0]       edge_sel,
  input  logic             cap_in,
  output logic             running,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cap_data,
  output logic             irq,
  output logic             ovf
);
  logic hit, restart, count_en, start_irq, wrap, cap_fire;
  logic [CNT_W-1:0] cap_q;
  logic irq_q, ovf_q;

  tcap_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .edge_sel(edge_sel), .hit(hit)
  );

  tcap_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .trig_start(trig_start), .trig_stop(trig_stop),
    .start_irq_en(start_irq_en), .running(running), .restart(restart),
    .count_en(count_en), .start_irq(start_irq)
  );

  tcap_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(restart), .count_en(count_en),
    .count(count), .wrap(wrap)
  );

  // capture only while enabled and not being stopped this cycle
  assign cap_fire = count_en & hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cap_q <= '0;
      irq_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (cap_fire) cap_q <= count;
      irq_q <= cap_fire | start_irq;
      if (restart)   ovf_q <= 1'b0;
      else if (wrap) ovf_q <= 1'b1;
    end

  assign cap_data = cap_q;
  assign irq      = irq_q;
  assign ovf      = ovf_q;
endmodule

// File: rtl/tcap_chk.sv
module tcap_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig_start,
  input logic             trig_stop,
  input logic             running,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] cap_data,
  input logic             irq,
  input logic             ovf
);
  logic [CNT_W-1:0] cnt_inc;
  assign cnt_inc = count + 1'b1;

  // R2
  start_loads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_start && !trig_stop |=> running && count == '0);
  // R2
  count_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running && !trig_stop && !trig_start |=> count == $past(cnt_inc));
  // R7
  stop_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_stop |=> !running && $stable(count));
  // R7
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !trig_start |=> $stable(count));
  // R8
  idle_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running || trig_stop) && !(trig_start && !trig_stop) |=> !irq && $stable(cap_data));
  // R4
  cap_needs_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_data) |-> irq);
  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !(trig_start && !trig_stop) |=> ovf);
endmodule

bind tcap_top tcap_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_start(trig_start), .trig_stop(trig_stop),
  .running(running), .count(count), .cap_data(cap_data), .irq(irq), .ovf(ovf)
);

// File: tb/tcap_top_bench.sv
`timescale 1ns/1ps
module tcap_top_bench;
  localparam int W = 8;
  localparam longint MASK = (64'd1 << W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic trig_start = 0, trig_stop = 0, start_irq_en = 0, cap_in = 0;
  logic [1:0] edge_sel = 2'b01;
  logic running, irq, ovf;
  logic [W-1:0] count, cap_data;

  always #10 clk = ~clk; // 50 MHz

  tcap_top #(.CNT_W(W)) u_tcap_top (
    .clk(clk), .rst_n(rst_n), .trig_start(trig_start), .trig_stop(trig_stop),
    .start_irq_en(start_irq_en), .edge_sel(edge_sel), .cap_in(cap_in),
    .running(running), .count(count), .cap_data(cap_data), .irq(irq), .ovf(ovf)
  );

  int n_chk = 0, n_bad = 0;
  string req = "R1";

  // behavioural reference
  bit m_run, m_irq, m_ovf;
  longint m_cnt, m_cap;
  bit hist[$];

  initial begin
    hist = '{0, 0, 0};
    m_run = 0; m_irq = 0; m_ovf = 0; m_cnt = 0; m_cap = 0;
  end

  always @(posedge clk) begin
    bit det, prev_v, cur_v, go, en;
    if (!rst_n) begin
      hist = '{0, 0, 0};
      m_run = 0; m_irq = 0; m_ovf = 0; m_cnt = 0; m_cap = 0;
    end else begin
      cur_v  = hist[1];   // second synchroniser stage
      prev_v = hist[2];
      case (edge_sel)
        2'b00: det = prev_v && !cur_v;
        2'b01: det = !prev_v && cur_v;
        2'b10: det = prev_v != cur_v;
        default: det = 0;
      endcase
      go = trig_start && !trig_stop;
      en = m_run && !trig_stop;
      m_irq = (go && start_irq_en) || (en && det);
      if (en && det) m_cap = m_cnt;
      if (go) begin
        m_cnt = 0; m_ovf = 0;
      end else if (en) begin
        if (m_cnt == MASK) m_ovf = 1;
        m_cnt = (m_cnt + 1) & MASK;
      end
      if (trig_stop) m_run = 0; else if (trig_start) m_run = 1;
      hist.push_front(cap_in);
      void'(hist.pop_back());
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: %s actual=%0d expected=%0d at %0t", req, tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("running", running, m_run);
    chk("count", count, m_cnt);
    chk("cap_data", cap_data, m_cap);
    chk("irq", irq, m_irq);
    chk("ovf", ovf, m_ovf);
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start(input bit ien);
    start_irq_en = ien; trig_start = 1; step(1); trig_start = 0;
  endtask

  task automatic pulse_stop();
    trig_stop = 1; step(1); trig_stop = 0;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    step(3);
    req = "R1";
    chk("reset running", running, 0); chk("reset count", count, 0);
    chk("reset irq", irq, 0); chk("reset ovf", ovf, 0);
    rst_n = 1; step(3);

    // R2: start without start interrupt
    req = "R2"; pulse_start(0); step(10);
    // R3: restart with start interrupt, count back to zero (R2)
    req = "R3"; pulse_start(1); step(5);

    // R4 R5: rising edges captured while counting continues
    req = "R4"; edge_sel = 2'b01;
    cap_in = 1; step(6); cap_in = 0; step(6);
    req = "R5"; cap_in = 1; step(4);
    chk("R5 count ahead of capture", (count > cap_data), 1);
    cap_in = 0; step(4);

    // R6: each edge selection, changed while running
    req = "R6"; edge_sel = 2'b00; cap_in = 1; step(5); cap_in = 0; step(5);
    edge_sel = 2'b10; cap_in = 1; step(5); cap_in = 0; step(5);
    edge_sel = 2'b11; cap_in = 1; step(5); cap_in = 0; step(5);
    edge_sel = 2'b10; cap_in = 1; step(1); edge_sel = 2'b00; step(5);

    // R7: stop holds count; stop beats start
    req = "R7"; pulse_stop(); step(4);
    trig_start = 1; trig_stop = 1; step(1); trig_start = 0; trig_stop = 0; step(3);

    // R8: edges while stopped
    req = "R8"; edge_sel = 2'b10; cap_in = 0; step(4); cap_in = 1; step(4);
    pulse_start(0); step(3);
    cap_in = 0; step(2); trig_stop = 1; step(1); trig_stop = 0; step(4);

    // R9: wrap and sticky overflow, cleared by start
    req = "R9"; pulse_start(0); step(600);
    chk("R9 ovf sticky", ovf, 1);
    pulse_start(0); step(2);
    chk("R9 ovf cleared", ovf, 0);

    // mixed random traffic against the model
    req = "R4";
    for (int i = 0; i < 5000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      cap_in = $urandom_range(0, 2) == 0 ? ~cap_in : cap_in;
      if (r < 3) edge_sel = 2'($urandom_range(0, 3));
      trig_start = (r == 50);
      trig_stop  = (r == 60) || (r == 61 && trig_start == 0 && $urandom_range(0, 1) == 1);
      start_irq_en = $urandom_range(0, 1);
      step(1);
    end
    trig_start = 0; trig_stop = 0; step(3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule